// File: doc/BRIEF.md
# I2C Burst-Mode Channel Writer

This block is the serial front end of a 40-channel converter register bank. It listens on an I2C bus as a write-only slave, samples SCL and SDA with a fast system clock, detects START and STOP conditions and pulls SDA low in the ninth clock of every byte it accepts. Each completed channel update leaves the block as a one-cycle write strobe that carries a channel index, a 2-bit destination-register select and a 12-bit data word. The register bank that takes the strobe sits outside this block.

Two addressing modes are supported. In three-byte mode the master sends a pointer byte naming a channel, followed by two data bytes. Writing the pointer value 0xFF starts a burst instead: the channel starts at 0 and steps up by one after every two-byte data pair, so one transaction can fill all channels with two bytes each. After channel 39 the block returns to three-byte mode. A STOP or a repeated START ends a burst at once.

Top module: `i2c_burst_writer`

## Requirements
- R1: The first byte after a START is the address byte: slave address in bits 7 to 1, R/W in bit 0. When bits 7 to 1 equal the parameter SLAVE_ADDR and bit 0 is 0, SDA is pulled low during the ninth clock of that byte. Every pointer and data byte that follows in the same transaction is acknowledged the same way.
- R2: An address byte with a different address, or with bit 0 equal to 1, is not acknowledged. Until the next START no later byte is acknowledged and no strobe is produced.
- R3: A pointer byte of 0xFF enters burst mode. The next data pair goes to channel 0, and each later pair goes to the channel one above the previous one.
- R4: After the pair for channel 39 has been written, the next byte is taken as a three-byte-mode pointer.
- R5: A STOP ends burst mode. The first byte after the next address byte is taken as a pointer.
- R6: In the first data byte, bits 7 to 6 form the register select and bits 5 to 0 are data bits 11 to 6. In the second data byte, bits 7 to 2 are data bits 5 to 0 and bits 1 to 0 have no effect on the output.
- R7: In three-byte mode, a pointer from 0 to 39 selects that channel for one data pair. A pointer from 40 to 254 is acknowledged, and so is its data pair, but no strobe is produced. After each pair the next byte is taken as a pointer again.
- R8: A repeated START clears burst mode and restarts address decoding.
- R9: The write strobe is high for exactly one system-clock cycle per completed data pair, and the channel, select and data outputs are valid while it is high.
- R10: SDA is pulled low only inside an acknowledge slot, never while the master is sending data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | I2C clock line as seen at the pin |
| sda_i | input | 1 | I2C data line as seen at the pin |
| sda_pull_o | output | 1 | 1 drives SDA low (open-drain acknowledge) |
| wr_en_o | output | 1 | One-cycle channel write strobe |
| wr_ch_o | output | 6 | Channel index of the write |
| wr_sel_o | output | 2 | Destination register select |
| wr_data_o | output | 12 | Data word to write |

## Verification
The main function is tried with single three-byte writes and with several pointer-and-pair groups in one transaction. These show that every pointer is decoded again after each pair. A full 40-channel burst followed by one more pointer group shows whether the channel steps up correctly and whether the block drops out of burst after channel 39. Short bursts that end in a STOP or a repeated START, followed by a byte that would be a data byte if the burst had survived, show that burst mode is cleared. Wrong addresses, read requests, out-of-range pointers and non-zero spare bits in the second data byte check that nothing reaches the strobe that should not.

// File: rtl/i2c_bw_pkg.sv
// Shared types and layout constants for the I2C burst channel writer.
// Assumes byte-wide I2C transfers and a 12-bit word split 6/6 over two bytes.
package i2c_bw_pkg;
    localparam int BYTE_W  = 8;
    localparam int SEL_W   = 2;
    localparam int HI_W    = BYTE_W - SEL_W;
    localparam int LO_W    = 6;
    localparam int WORD_W  = HI_W + LO_W;
    localparam int BIT_CW  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_MSB,
        ST_LSB
    } bw_state_t;
endpackage

// File: rtl/i2c_bw_sync.sv
// Synchronises SCL and SDA into the system clock domain and detects
// SCL edges plus START and STOP conditions.
// Assumes the system clock is many times faster than SCL and STAGES >= 2.
module i2c_bw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;
    localparam int L_SCL = 0;
    localparam int L_SDA = 1;

    logic [LINES-1:0] raw_w;
    logic [LINES-1:0] synced_w;
    logic [LINES-1:0] prev_q;

    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        // Shift the pin value through the flop chain, idle-high after reset.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2:0], raw_w[g]};
        end
        assign synced_w[g] = chain_q[STAGES-1];
    end

    // Keep the previous synchronised values for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= synced_w;
    end

    assign sda_s     = synced_w[L_SDA];
    assign scl_rise  =  synced_w[L_SCL] & ~prev_q[L_SCL];
    assign scl_fall  = ~synced_w[L_SCL] &  prev_q[L_SCL];
    assign start_det =  synced_w[L_SCL] &  prev_q[L_SCL] & prev_q[L_SDA] & ~synced_w[L_SDA];
    assign stop_det  =  synced_w[L_SCL] &  prev_q[L_SCL] & ~prev_q[L_SDA] & synced_w[L_SDA];
endmodule

// File: rtl/i2c_bw_byte.sv
// Bit-level receiver: collects eight data bits on SCL rising edges, offers
// the byte on the eighth falling edge, and holds the acknowledge through
// the ninth clock when told to.
// Assumes the master changes SDA only while SCL is low.
module i2c_bw_byte
    import i2c_bw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              ack_want,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              ack_drv,
    output logic              in_ack
);
    localparam logic [BIT_CW-1:0] FULL = BIT_CW'(BYTE_W);

    logic [BIT_CW-1:0] bit_cnt_q;
    logic [BYTE_W-1:0] shreg_q;

    assign byte_done = scl_fall & ~in_ack & (bit_cnt_q == FULL) & ~start_det & ~stop_det;
    assign rx_byte   = shreg_q;

    // Count bits, shift data in, and run the acknowledge slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            ack_drv   <= 1'b0;
            in_ack    <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt_q <= '0;
            ack_drv   <= 1'b0;
            in_ack    <= 1'b0;
        end else if (scl_rise && !in_ack && bit_cnt_q < FULL) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (scl_fall) begin
            if (in_ack) begin
                in_ack    <= 1'b0;
                ack_drv   <= 1'b0;
                bit_cnt_q <= '0;
            end else if (bit_cnt_q == FULL) begin
                in_ack    <= 1'b1;
                ack_drv   <= ack_want;
            end
        end
    end
endmodule

// File: rtl/i2c_burst_writer.sv
// Top of the I2C write-only channel front end. Decodes address, pointer
// and data bytes, runs three-byte and burst addressing, and emits one
// write strobe per completed data pair.
// Assumes NUM_CH <= 255 so that 0xFF never names a channel.
module i2c_burst_writer
    import i2c_bw_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h2A,
    parameter int         NUM_CH     = 40,
    parameter logic [7:0] BURST_PTR  = 8'hFF,
    parameter int         SYNC_STG   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_pull_o,
    output logic                      wr_en_o,
    output logic [$clog2(NUM_CH)-1:0] wr_ch_o,
    output logic [SEL_W-1:0]          wr_sel_o,
    output logic [WORD_W-1:0]         wr_data_o
);
    localparam int               CH_W    = $clog2(NUM_CH);
    localparam logic [CH_W-1:0]  LAST_CH = CH_W'(NUM_CH - 1);

    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              byte_done, ack_want, ack_drv, in_ack;
    logic [BYTE_W-1:0] rx_byte;

    bw_state_t         state_q;
    logic              burst_q;
    logic              ptr_ok_q;
    logic [CH_W-1:0]   ch_q;
    logic [BYTE_W-1:0] msb_q;

    i2c_bw_sync #(.STAGES(SYNC_STG)) sync_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_bw_byte byte_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .ack_want  (ack_want),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .ack_drv   (ack_drv),
        .in_ack    (in_ack)
    );

    assign sda_pull_o = ack_drv;

    // Decide whether the byte just received earns an acknowledge.
    always_comb begin
        case (state_q)
            ST_ADDR:                  ack_want = (rx_byte[7:1] == SLAVE_ADDR) && !rx_byte[0];
            ST_PTR, ST_MSB, ST_LSB:   ack_want = 1'b1;
            default:                  ack_want = 1'b0;
        endcase
    end

    // Byte-level protocol: mode, channel pointer and write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            burst_q   <= 1'b0;
            ptr_ok_q  <= 1'b0;
            ch_q      <= '0;
            msb_q     <= '0;
            wr_en_o   <= 1'b0;
            wr_ch_o   <= '0;
            wr_sel_o  <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (start_det) begin
                state_q  <= ST_ADDR;
                burst_q  <= 1'b0;
                ptr_ok_q <= 1'b0;
            end else if (stop_det) begin
                state_q  <= ST_IDLE;
                burst_q  <= 1'b0;
                ptr_ok_q <= 1'b0;
            end else if (byte_done) begin
                case (state_q)
                    ST_ADDR: state_q <= ack_want ? ST_PTR : ST_IDLE;
                    ST_PTR: begin
                        state_q <= ST_MSB;
                        if (rx_byte == BURST_PTR) begin
                            burst_q  <= 1'b1;
                            ptr_ok_q <= 1'b1;
                            ch_q     <= '0;
                        end else if (int'(rx_byte) < NUM_CH) begin
                            ptr_ok_q <= 1'b1;
                            ch_q     <= rx_byte[CH_W-1:0];
                        end else begin
                            ptr_ok_q <= 1'b0;
                        end
                    end
                    ST_MSB: begin
                        msb_q   <= rx_byte;
                        state_q <= ST_LSB;
                    end
                    ST_LSB: begin
                        if (ptr_ok_q) begin
                            wr_en_o   <= 1'b1;
                            wr_ch_o   <= ch_q;
                            wr_sel_o  <= msb_q[BYTE_W-1 -: SEL_W];
                            wr_data_o <= {msb_q[HI_W-1:0], rx_byte[BYTE_W-1 -: LO_W]};
                        end
                        if (burst_q && ch_q != LAST_CH) begin
                            ch_q    <= ch_q + 1'b1;
                            state_q <= ST_MSB;
                        end else begin
                            burst_q  <= 1'b0;
                            ptr_ok_q <= 1'b0;
                            state_q  <= ST_PTR;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_bw_checker.sv
// Protocol checker for the I2C burst channel writer, bound to the top.
// Assumes it sees the top's internal detect and mode signals via the bind.
module i2c_bw_checker #(
    parameter int NUM_CH = 40,
    parameter int CH_W   = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [CH_W-1:0] wr_ch,
    input logic            sda_pull,
    input logic            in_ack,
    input logic            start_det,
    input logic            stop_det,
    input logic            burst,
    input logic            in_addr,
    input logic            in_idle
);
    // R9: strobe lasts a single cycle
    a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R4: burst never runs past the last channel
    a_r4_ch_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_ch) < NUM_CH));

    // R5: STOP clears burst mode
    a_r5_stop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !burst);

    // R8: repeated START clears burst and returns to address decoding
    a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!burst && in_addr));

    // R10: SDA is pulled only inside an acknowledge slot
    a_r10_pull_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> in_ack);

    // R2: an unaddressed block stays silent
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        in_idle |-> (!sda_pull && !wr_en));
endmodule

bind i2c_burst_writer i2c_bw_checker #(.NUM_CH(NUM_CH), .CH_W($clog2(NUM_CH))) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en_o),
    .wr_ch     (wr_ch_o),
    .sda_pull  (sda_pull_o),
    .in_ack    (in_ack),
    .start_det (start_det),
    .stop_det  (stop_det),
    .burst     (burst_q),
    .in_addr   (state_q == i2c_bw_pkg::ST_ADDR),
    .in_idle   (state_q == i2c_bw_pkg::ST_IDLE)
);

// File: tb/i2c_burst_writer_tb_top.sv
// Bench: a behavioural I2C master drives the bus, expected writes go into
// a queue, and the strobe is compared with the queue on every clock.
module i2c_burst_writer_tb_top;
    localparam int Q  = 8;
    localparam int WD = 180000;
    localparam logic [6:0] ADDR = 7'h2A;

    typedef struct {
        int    ch;
        int    sel;
        int    data;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_pull, wr_en;
    logic [5:0]  wr_ch;
    logic [1:0]  wr_sel;
    logic [11:0] wr_data;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    bit    prev_en = 0;
    string cur_tag = "R9";
    exp_t  expq[$];

    always #2.5 clk = ~clk;

    assign sda_line = sda_pull ? 1'b0 : sda_m;

    i2c_burst_writer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_pull_o (sda_pull),
        .wr_en_o    (wr_en),
        .wr_ch_o    (wr_ch),
        .wr_sel_o   (wr_sel),
        .wr_data_o  (wr_data)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Strobe monitor: every clock, compare against the expected-write queue.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            chk(!prev_en, "R9 strobe longer than one cycle", 1, 0);
            if (expq.size() == 0) begin
                chk(0, {cur_tag, " unexpected write"}, int'(wr_ch), -1);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk(int'(wr_ch) == e.ch,     {e.tag, " channel"}, int'(wr_ch), e.ch);
                chk(int'(wr_sel) == e.sel,   {e.tag, " R6 select"}, int'(wr_sel), e.sel);
                chk(int'(wr_data) == e.data, {e.tag, " R6 data"}, int'(wr_data), e.data);
            end
        end
        prev_en = wr_en;
    end

    task automatic i2c_start();
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        sda_m = 1'b1; wait_clk(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clk(Q);
            scl_m = 1'b1; wait_clk(Q);
            if (i == 0) chk(sda_pull == 1'b0, "R10 pull during data bit", int'(sda_pull), 0);
            wait_clk(Q);
            scl_m = 1'b0; wait_clk(Q);
        end
        sda_m = 1'b1; wait_clk(Q);
        scl_m = 1'b1; wait_clk(Q);
        chk((sda_line == 1'b0) == exp_ack, {tag, " acknowledge"}, int'(sda_line == 1'b0), int'(exp_ack));
        wait_clk(Q);
        scl_m = 1'b0; wait_clk(Q);
    endtask

    function automatic logic [7:0] hi_b(input int sel, input int data);
        return {sel[1:0], data[11:6]};
    endfunction

    function automatic logic [7:0] lo_b(input int data, input int spare);
        return {data[5:0], spare[1:0]};
    endfunction

    // Send a data pair that must produce a write.
    task automatic pair_wr(input int ch, input int sel, input int data, input int spare, input string tag);
        exp_t e;
        e.ch = ch; e.sel = sel; e.data = data; e.tag = tag;
        expq.push_back(e);
        send_byte(hi_b(sel, data), 1'b1, tag);
        send_byte(lo_b(data, spare), 1'b1, tag);
    endtask

    task automatic open_wr();
        i2c_start();
        send_byte({ADDR, 1'b0}, 1'b1, "R1 address");
    endtask

    task automatic drain(input string tag);
        wait_clk(4*Q);
        chk(expq.size() == 0, {tag, " missing writes"}, expq.size(), 0);
        expq.delete();
    endtask

    initial begin
        wait_clk(5);
        chk(sda_pull == 1'b0 && wr_en == 1'b0, "R9 reset outputs", int'({sda_pull, wr_en}), 0);
        rst_n = 1'b1;
        wait_clk(5);
        chk(sda_pull == 1'b0 && wr_en == 1'b0, "R10 idle after reset", int'({sda_pull, wr_en}), 0);

        // R1 / R6 / R7: single three-byte writes
        cur_tag = "R7";
        open_wr();
        send_byte(8'd5, 1'b1, "R7 pointer");
        pair_wr(5, 3, 12'hABC, 0, "R6 ch5");
        i2c_stop();
        drain("R1");

        // R6: spare bits of the second data byte are ignored; R7 repeated pointers
        open_wr();
        send_byte(8'd0, 1'b1, "R7 pointer");
        pair_wr(0, 1, 12'h03F, 3, "R6 spare ones");
        send_byte(8'd39, 1'b1, "R7 pointer");
        pair_wr(39, 2, 12'hFC0, 2, "R7 ch39");
        send_byte(8'd17, 1'b1, "R7 pointer");
        pair_wr(17, 0, 12'h555, 1, "R7 ch17");
        i2c_stop();
        drain("R7");

        // R7: out-of-range pointers are acked but write nothing
        open_wr();
        send_byte(8'd40, 1'b1, "R7 pointer 40");
        send_byte(8'h12, 1'b1, "R7 data after 40");
        send_byte(8'h34, 1'b1, "R7 data after 40");
        send_byte(8'd254, 1'b1, "R7 pointer 254");
        send_byte(8'h56, 1'b1, "R7 data after 254");
        send_byte(8'h78, 1'b1, "R7 data after 254");
        i2c_stop();
        drain("R7");

        // R2: wrong address, then read request
        cur_tag = "R2";
        i2c_start();
        send_byte({7'h2B, 1'b0}, 1'b0, "R2 wrong address");
        send_byte(8'd3, 1'b0, "R2 ignored byte");
        send_byte(8'h40, 1'b0, "R2 ignored byte");
        send_byte(8'h00, 1'b0, "R2 ignored byte");
        i2c_stop();
        i2c_start();
        send_byte({ADDR, 1'b1}, 1'b0, "R2 read request");
        send_byte(8'd3, 1'b0, "R2 ignored byte");
        i2c_stop();
        drain("R2");

        // R3 / R4: full burst then one three-byte write
        cur_tag = "R3";
        open_wr();
        send_byte(8'hFF, 1'b1, "R3 burst pointer");
        for (int c = 0; c < 40; c++)
            pair_wr(c, c % 4, (c * 97 + 5) % 4096, c % 4, "R3 burst");
        send_byte(8'd2, 1'b1, "R4 pointer after burst");
        pair_wr(2, 1, 12'h246, 0, "R4 back to 3-byte");
        i2c_stop();
        drain("R4");

        // R5: STOP ends a partial burst
        cur_tag = "R5";
        open_wr();
        send_byte(8'hFF, 1'b1, "R5 burst pointer");
        pair_wr(0, 2, 12'h111, 0, "R5 burst ch0");
        pair_wr(1, 3, 12'h222, 0, "R5 burst ch1");
        i2c_stop();
        open_wr();
        send_byte(8'd10, 1'b1, "R5 pointer after stop");
        pair_wr(10, 0, 12'h333, 0, "R5 ch10");
        i2c_stop();
        drain("R5");

        // R8: repeated START ends a burst
        cur_tag = "R8";
        open_wr();
        send_byte(8'hFF, 1'b1, "R8 burst pointer");
        pair_wr(0, 1, 12'h7E1, 0, "R8 burst ch0");
        open_wr();
        send_byte(8'd7, 1'b1, "R8 pointer after restart");
        pair_wr(7, 2, 12'h0F0, 0, "R8 ch7");
        i2c_start();
        send_byte({7'h11, 1'b0}, 1'b0, "R8 restart wrong address");
        send_byte(8'd4, 1'b0, "R8 ignored byte");
        i2c_stop();
        drain("R8");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule